// File: doc/BRIEF.md
# Clock Phase Eye-Centering Sequencer

This block moves a receive clock phase into the middle of the error-free sampling window. It controls a fine phase shifter one step at a time. To test a phase, it clears an external sticky timing-error flag, waits a settle interval and then reads the flag. With the results it finds two edges. The first edge is where the flag goes from error to clean. That distance is the lead. The second edge is where the flag goes from clean back to error. That distance is the width. The block then steps backwards by half the width.

A single start pulse runs the whole sequence. At the end the block gives either a one-cycle done pulse, with the lead and width counts, or a one-cycle failure pulse when an edge search runs past its step limit. The settle interval and the step limit are parameters. The default settle interval is 5 ms at 125 MHz.

Top module: `phase_center_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, err_clr_o and ps_req_o are 0, and lead_o and width_o are 0.
- R2: A start_i pulse while idle raises busy_o from the next cycle. busy_o stays high until the cycle in which done_o or fail_o is asserted, and then it is low. A start_i while the sequence runs, or in the cycle of done_o or fail_o, has no effect.
- R3: Each probe pulses err_clr_o for one cycle. The error flag is sampled no earlier than SETTLE_CYCLES cycles after that pulse, and no phase step or new clear is issued before then. A flag value of 1 means a timing error.
- R4: A phase step is a one-cycle ps_req_o pulse, with ps_dir_o = 1 for forward and 0 for reverse. ps_req_o is issued only while ps_done_i is 1. The shifter drops ps_done_i in the cycle after a request and raises it again when the step has completed. The cycle right after a request is never taken as completion.
- R5: An edge search first probes its starting phase and keeps that value as the previous value. Then it repeats: one forward step, increment a step counter (cleared at the start of each search), probe. The first search ends when the previous probe was an error and the current one is clean. Its count is reported on lead_o.
- R6: The second search starts at the position where the first one ended. It ends when the previous probe was clean and the current one shows an error. Its count is reported on width_o.
- R7: After both edges are found, exactly width/2 (integer division) reverse steps are issued, and then done_o pulses. The final phase is the lead position plus width minus width/2.
- R8: In each probe, the edge test comes before the limit test. If the step count exceeds STEP_LIMIT with no edge, fail_o pulses and no further steps are issued. An edge found at count STEP_LIMIT+1 still succeeds.
- R9: done_o and fail_o are single-cycle pulses and are never high together.
- R10: lead_o and width_o are cleared when a run starts. They keep their values while the block is idle, until the next accepted start, whatever the error flag does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a centring run while idle |
| err_flag_i | input | 1 | Sticky timing-error flag, already synchronised |
| err_clr_o | output | 1 | One-cycle clear of the error flag |
| ps_req_o | output | 1 | One-cycle phase-step request |
| ps_dir_o | output | 1 | Step direction, 1 forward, 0 reverse |
| ps_done_i | input | 1 | High when the phase shifter is ready for a step |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle step-limit failure pulse |
| lead_o | output | CNT_W | Steps to the error-to-clean edge |
| width_o | output | CNT_W | Steps across the clean region |

## Verification
The assertions assume that ps_done_i drops in the cycle after each request and stays low until the step is complete. They also assume that err_flag_i is already in the clock domain and only changes in response to phase or clear. The bench shifter model keeps to this. It holds ps_done_i low for a fixed three cycles after every request. It moves a phase counter by one per request. It sets the sticky flag from a periodic error band and clears it only on err_clr_o. The table chooses the band and the starting phase so that each edge lands at a known count. This includes one edge at the limit plus one and one just past it.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CLR, SQ_SETTLE, SQ_STEP, SQ_BACK, SQ_DONE, SQ_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_IDLE, SP_ARM, SP_GUARD, SP_WAIT
  } step_state_e;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } step_dir_e;
endpackage

// File: rtl/pe_settle_timer.sv
module pe_settle_timer #(
  parameter int unsigned CYCLES = 625000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int unsigned TW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [TW-1:0] LOAD_VAL = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pe_step_counter.sv
module pe_step_counter #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pe_step_port.sv
module pe_step_port
  import pe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic dir_i,
  input  logic ps_done_i,
  output logic ps_req_o,
  output logic ps_dir_o,
  output logic busy_o,
  output logic cmpl_o
);
  step_state_e st_q, st_d;
  logic        dir_q;

  always_comb begin
    st_d     = st_q;
    ps_req_o = 1'b0;
    cmpl_o   = 1'b0;
    unique case (st_q)
      SP_IDLE:  if (go_i) st_d = SP_ARM;
      SP_ARM: begin
        if (ps_done_i) begin
          ps_req_o = 1'b1;
          st_d     = SP_GUARD;
        end
      end
      // shifter needs one cycle to drop its done
      SP_GUARD: st_d = SP_WAIT;
      SP_WAIT: begin
        if (ps_done_i) begin
          cmpl_o = 1'b1;
          st_d   = SP_IDLE;
        end
      end
      default:  st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SP_IDLE;
      dir_q <= DIR_FWD;
    end else begin
      st_q <= st_d;
      if (st_q == SP_IDLE && go_i) dir_q <= dir_i;
    end
  end

  assign ps_dir_o = dir_q;
  assign busy_o   = (st_q != SP_IDLE);
endmodule

// File: rtl/phase_center_seq.sv
module phase_center_seq
  import pe_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 625000,
  parameter int unsigned STEP_LIMIT    = 5000,
  parameter int unsigned CNT_W         = $clog2(STEP_LIMIT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             err_flag_i,
  output logic             err_clr_o,
  output logic             ps_req_o,
  output logic             ps_dir_o,
  input  logic             ps_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] lead_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(STEP_LIMIT);

  seq_state_e       st_q, st_d;
  logic             search_q;   // 0: seek clean, 1: seek error
  logic             first_q;
  logic             prev_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] lead_q, width_q;

  logic             expire, hit, over, accept;
  logic             sp_go, sp_dir, sp_busy, sp_cmpl;
  logic             cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt;

  pe_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (st_q == SQ_CLR),
    .expire_o (expire)
  );

  pe_step_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  pe_step_port u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (sp_go),
    .dir_i     (sp_dir),
    .ps_done_i (ps_done_i),
    .ps_req_o  (ps_req_o),
    .ps_dir_o  (ps_dir_o),
    .busy_o    (sp_busy),
    .cmpl_o    (sp_cmpl)
  );

  assign accept  = (st_q == SQ_IDLE) && start_i;
  assign hit     = !first_q && (prev_q != search_q) && (err_flag_i == search_q);
  assign over    = (cnt > LIMIT_C);
  assign sp_dir  = (st_q == SQ_BACK) ? DIR_REV : DIR_FWD;
  assign sp_go   = !sp_busy && ((st_q == SQ_STEP) ||
                                ((st_q == SQ_BACK) && (rem_q != '0)));
  assign cnt_inc = (st_q == SQ_STEP) && sp_cmpl;
  assign cnt_clr = accept ||
                   ((st_q == SQ_SETTLE) && expire && hit && !search_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:   if (start_i) st_d = SQ_CLR;
      SQ_CLR:    st_d = SQ_SETTLE;
      SQ_SETTLE: begin
        if (expire) begin
          if (first_q)       st_d = SQ_STEP;
          else if (hit)      st_d = search_q ? SQ_BACK : SQ_CLR;
          else if (over)     st_d = SQ_FAIL;
          else               st_d = SQ_STEP;
        end
      end
      SQ_STEP:   if (sp_cmpl) st_d = SQ_CLR;
      SQ_BACK:   if (rem_q == '0 && !sp_busy) st_d = SQ_DONE;
      SQ_DONE,
      SQ_FAIL:   st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SQ_IDLE;
      search_q <= 1'b0;
      first_q  <= 1'b1;
      prev_q   <= 1'b0;
      rem_q    <= '0;
      lead_q   <= '0;
      width_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        search_q <= 1'b0;
        first_q  <= 1'b1;
        lead_q   <= '0;
        width_q  <= '0;
      end
      if (st_q == SQ_SETTLE && expire) begin
        if (first_q) begin
          prev_q  <= err_flag_i;
          first_q <= 1'b0;
        end else if (hit) begin
          if (!search_q) begin
            lead_q   <= cnt;
            search_q <= 1'b1;
            first_q  <= 1'b1;
          end else begin
            width_q <= cnt;
            rem_q   <= cnt >> 1;
          end
        end else begin
          prev_q <= err_flag_i;
        end
      end
      if (st_q == SQ_BACK && sp_cmpl) rem_q <= rem_q - 1'b1;
    end
  end

  assign err_clr_o = (st_q == SQ_CLR);
  assign busy_o    = (st_q != SQ_IDLE) && (st_q != SQ_DONE) && (st_q != SQ_FAIL);
  assign done_o    = (st_q == SQ_DONE);
  assign fail_o    = (st_q == SQ_FAIL);
  assign lead_o    = lead_q;
  assign width_o   = width_q;
endmodule

// File: rtl/pe_center_checker.sv
module pe_center_checker #(
  parameter int unsigned SETTLE_CYCLES = 625000,
  parameter int unsigned CNT_W         = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             err_clr_o,
  input logic             ps_req_o,
  input logic             ps_done_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] lead_o,
  input logic [CNT_W-1:0] width_o
);
  int unsigned since_q;
  logic        pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= SETTLE_CYCLES;
      pend_q  <= 1'b0;
    end else begin
      if (err_clr_o)                   since_q <= 1;
      else if (since_q < SETTLE_CYCLES) since_q <= since_q + 1;
      if (err_clr_o)     pend_q <= 1'b1;
      else if (ps_req_o) pend_q <= 1'b0;
    end
  end

  a_r2_busy_ends_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o || fail_o));
  a_r2_start_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o && !fail_o) |=> busy_o);
  a_r3_settle_before_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_req_o && pend_q) |-> (since_q >= SETTLE_CYCLES));
  a_r3_settle_before_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_o && pend_q) |-> (since_q >= SETTLE_CYCLES));
  a_r4_req_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_req_o |-> ps_done_i);
  a_r4_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_req_o |=> !ps_req_o);
  a_r4_req_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_req_o || err_clr_o) |-> busy_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_fail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fail_o);
  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(lead_o) && $stable(width_o)));
endmodule

bind phase_center_seq pe_center_checker #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .CNT_W        (CNT_W)
) u_pe_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .err_clr_o (err_clr_o),
  .ps_req_o  (ps_req_o),
  .ps_done_i (ps_done_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .lead_o    (lead_o),
  .width_o   (width_o)
);

// File: tb/tb_phase_center_seq.sv
`timescale 1ns/1ps
module tb_phase_center_seq;
  localparam int SETTLE = 4;
  localparam int LIMIT  = 40;
  localparam int CW     = $clog2(LIMIT + 2);
  localparam int LAT    = 3;
  localparam int NV     = 9;

  // start phase, band period, error band length, lead, width, fail, final phase
  localparam int V_P0 [NV] = '{ 0,  8,  3,  5, 2,  9,  8, 0,  3};
  localparam int V_PER[NV] = '{16, 16, 20, 10, 9, 60, 60, 8,  8};
  localparam int V_BAD[NV] = '{ 4,  4,  6,  3, 2, 50, 50, 8,  0};
  localparam int V_LD [NV] = '{ 4, 12,  3,  8, 9, 41,  0, 0,  0};
  localparam int V_WD [NV] = '{12, 12, 14,  7, 7, 10,  0, 0,  0};
  localparam int V_FL [NV] = '{ 0,  0,  0,  0, 0,  0,  1, 1,  1};
  localparam int V_POS[NV] = '{10, 26, 13, 17, 15, 55, 49, 41, 44};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic err_flag_i;
  logic err_clr_o, ps_req_o, ps_dir_o, ps_done_i;
  logic busy_o, done_o, fail_o;
  logic [CW-1:0] lead_o, width_o;

  int n_chk = 0, n_fail = 0;
  int per_v = 16, bad_v = 4;
  logic load_en = 1'b0;
  int load_val = 0;
  int pos;
  int lat_q;
  logic err_q;
  int since_clr = 1000, gap_viol = 0, busy_req = 0;
  int done_cnt = 0, fail_cnt = 0, clr_cnt = 0, req_cnt = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  phase_center_seq #(.SETTLE_CYCLES(SETTLE), .STEP_LIMIT(LIMIT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .err_flag_i(err_flag_i),
    .err_clr_o(err_clr_o), .ps_req_o(ps_req_o), .ps_dir_o(ps_dir_o),
    .ps_done_i(ps_done_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .lead_o(lead_o), .width_o(width_o)
  );

  function automatic logic is_bad(int p);
    if (per_v <= 0) return 1'b0;
    return ((p % per_v) < bad_v);
  endfunction

  // phase shifter and sticky error detector model
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos   <= 0;
      lat_q <= 0;
      err_q <= 1'b0;
    end else begin
      if (load_en) pos <= load_val;
      else if (ps_req_o) pos <= ps_dir_o ? pos + 1 : pos - 1;
      if (ps_req_o) lat_q <= LAT;
      else if (lat_q > 0) lat_q <= lat_q - 1;
      if (err_clr_o || load_en) err_q <= 1'b0;
      else err_q <= err_q | is_bad(pos);
    end
  end
  assign ps_done_i  = (lat_q == 0);
  assign err_flag_i = err_q;

  always @(negedge clk_i) begin
    if (err_clr_o) begin since_clr = 0; clr_cnt++; end
    else since_clr++;
    if (ps_req_o) begin
      req_cnt++;
      if (since_clr < SETTLE) gap_viol++;
      if (!ps_done_i) busy_req++;
    end
    if (done_o) done_cnt++;
    if (fail_o) fail_cnt++;
  end

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_case(int idx, int p0, int per, int bad,
                          int e_ld, int e_wd, int e_fl, int e_pos, int poke_start);
    int d0, f0, guard;
    @(negedge clk_i);
    per_v = per; bad_v = bad; load_val = p0; load_en = 1'b1;
    @(negedge clk_i);
    load_en = 1'b0;
    d0 = done_cnt; f0 = fail_cnt;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    check("R10 lead cleared at start", int'(lead_o), 0);
    check("R10 width cleared at start", int'(width_o), 0);
    guard = 0;
    while (!done_o && !fail_o && guard < 30000) begin
      if (poke_start != 0 && guard == 30) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    check("R2 busy low at end pulse", int'(busy_o), 0);
    check("R8 fail outcome", int'(fail_o), e_fl);
    check("R5 lead", int'(lead_o), e_ld);
    check("R6 width", int'(width_o), e_wd);
    repeat (40) @(negedge clk_i);
    check("R7 R8 final phase", pos, e_pos);
    check("R9 single end pulse", (done_cnt - d0) + (fail_cnt - f0), 1);
    check("R2 no restart", int'(busy_o), 0);
    if (idx < 0) $display("unused");
  endtask

  initial begin
    int c0, r0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 fail", int'(fail_o), 0);
    check("R1 clr", int'(err_clr_o), 0);
    check("R1 req", int'(ps_req_o), 0);
    check("R1 lead", int'(lead_o), 0);
    check("R1 width", int'(width_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++)
      run_case(i, V_P0[i], V_PER[i], V_BAD[i], V_LD[i], V_WD[i], V_FL[i], V_POS[i], 0);

    // R2: start while running is ignored
    run_case(100, 0, 16, 4, 4, 12, 0, 10, 1);

    // R10: outputs hold while idle even as the flag changes
    per_v = 8; bad_v = 8;
    c0 = clr_cnt; r0 = req_cnt;
    repeat (60) @(negedge clk_i);
    check("R10 lead held", int'(lead_o), 4);
    check("R10 width held", int'(width_o), 12);
    check("R10 no probe while idle", (clr_cnt - c0) + (req_cnt - r0), 0);

    check("R3 settle gap before step", gap_viol, 0);
    check("R4 request only when ready", busy_req, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule